// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

A single-port synchronous memory with register-to-register timing. Each rising clock edge samples one command: the address, an active-low chip select, an active-low write enable and four active-low lane write selects. A read returns its word in the cycle that follows the sampling edge. A write places its data on the bus one cycle after its command. The block captures that data on the next edge and parks it in a pending-write register. The register drains into the array when the next write's data arrives, or on a deselected cycle.

The 36-bit word is split into four 9-bit lanes. Any subset of lanes can be written. A read that targets a word with uncommitted data (pending, or arriving on the bus at the same edge) gets the new lanes merged over the stored ones. Output enable and sleep gate the output drivers without waiting for a clock edge.

On chip the data bus is a separate input, output and output-enable. The bidirectional pad is formed outside the block from these three signals.

Top module: `lw_sram`

## Requirements
- R1: While reset is asserted and after it is released, with no read issued, `dq_oe_o` is 0.
- R2: A read command (`sel_ni`=0, `we_ni`=1) sampled at edge k sets `dq_oe_o`=1 and places the word at `addr_i` on `dq_o` from edge k until edge k+1 (with `oe_ni`=0 and `sleep_i`=0).
- R3: A write command (`sel_ni`=0, `we_ni`=0, at least one `bwe_ni` bit 0) sampled at edge k leaves `dq_oe_o`=0 for the following cycle. Its data is taken from `dq_i` at edge k+1.
- R4: `bwe_ni[i]`=0 writes lane i, bits [9i+8:9i]. `bwe_ni[i]`=1 leaves that lane's stored bits unchanged.
- R5: A read whose address matches a write that is not yet committed returns the written lanes from that write and the stored lanes elsewhere. This holds when the data is pending and when it arrives on `dq_i` at the read's own edge.
- R6: A deselect (`sel_ni`=1) performs no access and leaves `dq_oe_o`=0 for the next cycle.
- R7: `we_ni`=0 with `bwe_ni`=4'b1111 writes nothing and acts as a read: the stored word is driven in the next cycle.
- R8: `sleep_i`=1 forces `dq_oe_o` to 0 at once, even during a read cycle. Clearing it restores the drive.
- R9: `oe_ni`=1 forces `dq_oe_o` to 0 at once, even during a read cycle. Clearing it restores the drive.
- R10: Writes issued on consecutive cycles to different addresses are all retained. Each pending write is committed when the following write's data is captured.
- R11: `dq_i` is ignored in every cycle that does not follow a write command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address, sampled at the edge |
| sel_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write enable, active low |
| bwe_ni | input | 4 | Lane write selects, active low, bit i for lane i |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep, forces outputs off |
| dq_i | input | 36 | Data from the bus (write data) |
| dq_o | output | 36 | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The assertions assume that the command inputs are settled at each rising edge. They also assume that the write data for a command at edge k is on `dq_i` throughout the following cycle, and that the bus is never driven by both sides at once.

The bench meets these conditions as follows. It changes inputs only on falling edges and places write data exactly one step after its command. It drives `dq_i` with a decoy pattern in every other cycle, so the ignore rule of R11 is exercised. It toggles `oe_ni` and `sleep_i` mid-cycle only while a read word is being driven.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;

  // take[i]=1 selects lane i from over, else from base
  function automatic word_t lane_merge(word_t base, word_t over, lane_t take);
    word_t r;
    r = base;
    for (int i = 0; i < LANES; i++)
      if (take[i]) r[i*LANE_W +: LANE_W] = over[i*LANE_W +: LANE_W];
    return r;
  endfunction
endpackage

// File: rtl/lw_sram_array.sv
module lw_sram_array
  import lw_sram_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  word_t         wr_data_i,
  input  lane_t         wr_lane_i,
  input  logic [AW-1:0] rd_addr_i,
  output word_t         rd_data_o
);
  word_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= lane_merge(mem[wr_addr_i], wr_data_i, wr_lane_i);
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/lw_sram_pend.sv
module lw_sram_pend
  import lw_sram_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_cmd_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  lane_t         cmd_lane_i,
  input  logic          free_i,
  input  word_t         bus_i,
  input  logic [AW-1:0] rd_addr_i,
  input  word_t         arr_data_i,
  output word_t         rd_data_o,
  output logic          cm_en_o,
  output logic [AW-1:0] cm_addr_o,
  output word_t         cm_data_o,
  output lane_t         cm_lane_o
);
  // write command seen, data due on bus this cycle
  logic          fly_q;
  logic [AW-1:0] fly_addr_q;
  lane_t         fly_lane_q;
  // captured write awaiting commit
  logic          pend_q;
  logic [AW-1:0] pend_addr_q;
  word_t         pend_data_q;
  lane_t         pend_lane_q;

  assign cm_en_o   = pend_q & (fly_q | free_i);
  assign cm_addr_o = pend_addr_q;
  assign cm_data_o = pend_data_q;
  assign cm_lane_o = pend_lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fly_q       <= 1'b0;
      fly_addr_q  <= '0;
      fly_lane_q  <= '0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      pend_lane_q <= '0;
    end else begin
      fly_q <= wr_cmd_i;
      if (wr_cmd_i) begin
        fly_addr_q <= cmd_addr_i;
        fly_lane_q <= cmd_lane_i;
      end
      if (fly_q) begin
        pend_q      <= 1'b1;
        pend_addr_q <= fly_addr_q;
        pend_lane_q <= fly_lane_q;
        pend_data_q <= bus_i;
      end else if (cm_en_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  // newest data wins: array, then pending, then data arriving now
  word_t m_pend;
  always_comb begin
    m_pend = arr_data_i;
    if (pend_q && pend_addr_q == rd_addr_i) m_pend = lane_merge(m_pend, pend_data_q, pend_lane_q);
    rd_data_o = m_pend;
    if (fly_q && fly_addr_q == rd_addr_i) rd_data_o = lane_merge(m_pend, bus_i, fly_lane_q);
  end

  AST_CAPTURE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fly_q |=> pend_q); // R3
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !fly_q && !free_i) |=> (pend_q && $stable(pend_addr_q) && $stable(pend_data_q))); // R10
  AST_FREE_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !fly_q && free_i) |=> !pend_q); // R6
endmodule

// File: rtl/lw_sram_io.sv
module lw_sram_io
  import lw_sram_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_cmd_i,
  input  word_t rd_data_i,
  input  logic  oe_ni,
  input  logic  sleep_i,
  output logic  drv_o,
  output word_t q_o,
  output logic  q_en_o
);
  logic  drv_q;
  word_t q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q <= 1'b0;
      q_q   <= '0;
    end else begin
      drv_q <= rd_cmd_i;
      if (rd_cmd_i) q_q <= rd_data_i;
    end
  end

  assign drv_o  = drv_q;
  assign q_o    = q_q;
  assign q_en_o = drv_q & ~oe_ni & ~sleep_i;
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              sel_ni,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bwe_ni,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic [WORD_W-1:0] dq_i,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic          no_lane, wr_cmd, rd_cmd, cm_en, drv;
  logic [AW-1:0] cm_addr;
  word_t         cm_data, arr_data, rd_data;
  lane_t         cm_lane;

  assign no_lane = &bwe_ni;
  assign wr_cmd  = ~sel_ni & ~we_ni & ~no_lane;
  // a write with no lane selected is a dummy read
  assign rd_cmd  = ~sel_ni & (we_ni | no_lane);

  lw_sram_array #(.DEPTH(DEPTH)) u_array (
    .clk_i     (clk_i),
    .wr_en_i   (cm_en),
    .wr_addr_i (cm_addr),
    .wr_data_i (cm_data),
    .wr_lane_i (cm_lane),
    .rd_addr_i (addr_i),
    .rd_data_o (arr_data)
  );

  lw_sram_pend #(.AW(AW)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_cmd_i   (wr_cmd),
    .cmd_addr_i (addr_i),
    .cmd_lane_i (~bwe_ni),
    .free_i     (sel_ni),
    .bus_i      (dq_i),
    .rd_addr_i  (addr_i),
    .arr_data_i (arr_data),
    .rd_data_o  (rd_data),
    .cm_en_o    (cm_en),
    .cm_addr_o  (cm_addr),
    .cm_data_o  (cm_data),
    .cm_lane_o  (cm_lane)
  );

  lw_sram_io u_io (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_cmd_i  (rd_cmd),
    .rd_data_i (rd_data),
    .oe_ni     (oe_ni),
    .sleep_i   (sleep_i),
    .drv_o     (drv),
    .q_o       (dq_o),
    .q_en_o    (dq_oe_o)
  );

  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd |=> drv); // R2
  AST_WRITE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd |=> !dq_oe_o); // R3
  AST_DESEL_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> !dq_oe_o); // R6
endmodule

// File: tb/lw_sram_test.sv
module lw_sram_test;
  localparam int unsigned DEPTH = 256;
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [35:0] DECOY = 36'hA5C3_96E1F;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          sel_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b0, sleep_i = 1'b0;
  logic [3:0]    bwe_ni = 4'hF;
  logic [35:0]   dq_i = '0, dq_o;
  logic          dq_oe_o;

  int total = 0, fails = 0;
  logic [35:0] ref_mem [DEPTH];
  logic        wr_due = 1'b0;
  logic [AW-1:0] wr_due_addr;
  logic [3:0]  wr_due_mask;
  logic [35:0] wr_due_data;

  localparam int K_IDLE = 0, K_READ = 1, K_WRITE = 2, K_DUMMY = 3;

  always #4 clk_i = ~clk_i;

  lw_sram #(.DEPTH(DEPTH)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .sel_ni(sel_ni), .we_ni(we_ni),
    .bwe_ni(bwe_ni), .oe_ni(oe_ni), .sleep_i(sleep_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  task automatic check(input string tag, input logic ok, input logic [36:0] act, input logic [36:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check after the next rising edge
  task automatic step(input int kind, input logic [AW-1:0] a, input logic [3:0] m,
                      input logic [35:0] d, input string tag);
    logic [35:0] exp;
    if (wr_due) begin
      dq_i = wr_due_data;
      for (int i = 0; i < 4; i++)
        if (!wr_due_mask[i]) ref_mem[wr_due_addr][i*9 +: 9] = wr_due_data[i*9 +: 9];
      wr_due = 1'b0;
    end else begin
      dq_i = DECOY;
    end
    addr_i = a;
    sel_ni = (kind == K_IDLE);
    we_ni  = !(kind == K_WRITE || kind == K_DUMMY);
    bwe_ni = (kind == K_WRITE) ? m : 4'hF;
    exp = ref_mem[a];
    if (kind == K_WRITE) begin
      wr_due = 1'b1; wr_due_addr = a; wr_due_mask = m; wr_due_data = d;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    if (kind == K_READ || kind == K_DUMMY)
      check(tag, dq_oe_o && dq_o == exp, {dq_oe_o, dq_o}, {1'b1, exp});
    else
      check(tag, !dq_oe_o, {36'h0, dq_oe_o}, 37'h0);
  endtask

  task automatic t_reset;
    check("R1 reset", !dq_oe_o, {36'h0, dq_oe_o}, 37'h0);
    step(K_IDLE, 0, 4'hF, 0, "R1 idle after reset");
  endtask

  task automatic t_basic;
    step(K_WRITE, 8'h10, 4'h0, 36'h1_2345_6789, "R3 write hi-z");
    step(K_IDLE,  8'h00, 4'hF, 0, "R6 deselect hi-z");
    step(K_READ,  8'h10, 4'hF, 0, "R2 read word");
    step(K_WRITE, 8'h11, 4'h0, 36'hF_0F0F_0F0F, "R3 write hi-z");
    step(K_IDLE,  8'h00, 4'hF, 0, "R6 deselect");
    step(K_READ,  8'h11, 4'hF, 0, "R2 read second");
    step(K_READ,  8'h10, 4'hF, 0, "R11 decoy ignored");
  endtask

  task automatic t_lanes;
    step(K_WRITE, 8'h20, 4'h0, 36'h0_0000_0000, "R4 clear");
    step(K_WRITE, 8'h20, 4'b1010, 36'hF_FFFF_FFFF, "R4 lanes 0,2");
    step(K_IDLE,  8'h00, 4'hF, 0, "R4 idle");
    step(K_READ,  8'h20, 4'hF, 0, "R4 lanes 0,2 only");
    step(K_WRITE, 8'h20, 4'b0111, 36'hA_BCDE_F012, "R4 lane 3");
    step(K_IDLE,  8'h00, 4'hF, 0, "R4 idle");
    step(K_READ,  8'h20, 4'hF, 0, "R4 lane 3 only");
  endtask

  task automatic t_hit;
    step(K_WRITE, 8'h30, 4'h0, 36'h1_1111_1111, "R5 base");
    step(K_IDLE,  8'h00, 4'hF, 0, "R5 idle");
    step(K_WRITE, 8'h30, 4'b1001, 36'h2_2222_2222, "R5 partial");
    step(K_READ,  8'h30, 4'hF, 0, "R5 in-flight merge");
    step(K_READ,  8'h30, 4'hF, 0, "R5 pending merge");
    step(K_WRITE, 8'h31, 4'h0, 36'h3_3333_3333, "R5 other");
    step(K_READ,  8'h30, 4'hF, 0, "R5 after commit");
  endtask

  task automatic t_dummy;
    step(K_DUMMY, 8'h30, 4'hF, 0, "R7 dummy read drives");
    step(K_READ,  8'h30, 4'hF, 0, "R7 dummy wrote nothing");
  endtask

  task automatic t_async;
    step(K_READ, 8'h11, 4'hF, 0, "R9 read");
    oe_ni = 1'b1; #1;
    check("R9 oe off", !dq_oe_o, {36'h0, dq_oe_o}, 37'h0);
    oe_ni = 1'b0; #1;
    check("R9 oe on", dq_oe_o, {36'h0, dq_oe_o}, 37'h1);
    step(K_READ, 8'h10, 4'hF, 0, "R8 read");
    sleep_i = 1'b1; #1;
    check("R8 sleep off", !dq_oe_o, {36'h0, dq_oe_o}, 37'h0);
    sleep_i = 1'b0; #1;
    check("R8 sleep on", dq_oe_o, {36'h0, dq_oe_o}, 37'h1);
  endtask

  task automatic t_b2b;
    for (int i = 0; i < 6; i++)
      step(K_WRITE, AW'(8'h40 + i), 4'h0, 36'(36'h5_0000_0000 + i * 36'h0_0101_1337), "R10 burst");
    step(K_WRITE, 8'h42, 4'b1100, 36'h7_7777_7777, "R10 overwrite");
    step(K_IDLE, 8'h00, 4'hF, 0, "R10 idle");
    for (int i = 0; i < 6; i++)
      step(K_READ, AW'(8'h40 + i), 4'hF, 0, "R10 read back");
    step(K_READ, 8'hFF, 4'hF, 0, "R2 top address");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    ref_mem[8'hFF] = 36'h0_0000_0000;
    repeat (3) @(negedge clk_i);
    check("R1 in reset", !dq_oe_o, {36'h0, dq_oe_o}, 37'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    step(K_WRITE, 8'hFF, 4'h0, 36'h0_0000_0000, "R3 init top");
    t_basic();
    t_lanes();
    t_hit();
    t_dummy();
    t_async();
    t_b2b();
    step(K_IDLE, 8'h00, 4'hF, 0, "R6 final");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule